// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general purpose I/O controller for a pin count that is a whole number of 32-pin banks. Software reaches it through a plain 32-bit register port: one write strobe with address and data, and a read data bus that follows the address in the same cycle. Every pin has an output value, an output enable and a sampled input level. Each pin can also flag a rising and a falling transition into a sticky status bit. A single interrupt line is high while any status bit is set.

The registers are grouped by function. Each function has one 32-bit word per bank, and the groups sit back to back, so the distance between groups grows with the bank count. Outputs are never written directly. A pin is driven high by writing a one to its set word and driven low by writing a one to its clear word. Software can therefore change single pins without reading first. Inputs pass through a synchronizer before they are read or examined for edges.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The word index is the byte address divided by 4, and equals kind*NBANK + bank, where NBANK = NUM_PINS/32. Pin p sits at bank p/32, bit p%32. The kind codes are: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status. Word indices at or above 7*NBANK, and byte addresses whose two low bits are not 00, read as 0 and ignore writes.
- R2: After reset every register is 0: pin_oe and pin_out are all 0, irq is 0, and all words read 0 while pin_in is 0.
- R3: Writing a word of kind 2 sets pin_out for each 1 bit and leaves pins under 0 bits unchanged. The set word reads back as 0.
- R4: Writing a word of kind 3 clears pin_out for each 1 bit and leaves pins under 0 bits unchanged. The clear word reads back as 0.
- R5: The direction word (kind 1) is read/write. A bit value of 1 drives pin_oe high for that pin and 0 makes the pin an input.
- R6: The level word (kind 0) returns pin_in after a two-stage synchronizer. Writes to it are ignored.
- R7: A 0 to 1 change of a synchronized pin whose rising-enable bit (kind 4) is 1 sets that pin's status bit. With the enable at 0, the change sets nothing.
- R8: A 1 to 0 change of a synchronized pin whose falling-enable bit (kind 5) is 1 sets that pin's status bit. With the enable at 0, the change sets nothing.
- R9: Status bits (kind 6) clear when a 1 is written to them, and 0 bits leave them unchanged. An enabled edge that is detected in the same cycle as a clearing write leaves the bit set.
- R10: irq is 1 exactly while at least one status bit in any bank is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| pin_in | input | NUM_PINS | Raw pin levels |
| pin_out | output | NUM_PINS | Pin output values |
| pin_oe | output | NUM_PINS | Pin output enables |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bench builds the block with 64 pins (two banks) and an 8-bit address. This gives 14 mapped words inside a 64-word space, so the whole address space can be swept, including the unmapped words and the point where the group stride crosses into the second bank. Every pin is stepped through set, clear, rising and falling capture one at a time, and expected words are computed from the pin number and the kind/bank formula. A clearing write is timed into the exact cycle where an edge is detected, to check that the edge wins.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int WORD_W    = 32;
   localparam int NUM_KINDS = 7;

   typedef enum logic [2:0] {
      K_LEVEL = 3'd0,
      K_DIR   = 3'd1,
      K_SET   = 3'd2,
      K_CLR   = 3'd3,
      K_RISE  = 3'd4,
      K_FALL  = 3'd5,
      K_STAT  = 3'd6
   } reg_kind_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W           = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] synced,
   output logic [W-1:0] rise_ev,
   output logic [W-1:0] fall_ev
);
   logic [W-1:0] stg [SYNC_STAGES];
   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
         prev_q <= '0;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
         prev_q <= stg[SYNC_STAGES-1];
      end
   end

   assign synced  = stg[SYNC_STAGES-1];
   assign rise_ev = synced & ~prev_q;
   assign fall_ev = ~synced & prev_q;
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_bank_pkg::*;
#(
   parameter int NBANK  = 2,
   parameter int ADDR_W = 8,
   parameter int BANK_W = 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output reg_kind_e         kind,
   output logic [BANK_W-1:0] bank
);
   localparam int WW     = ADDR_W - 2;
   localparam int NWORDS = NUM_KINDS * NBANK;

   logic [WW-1:0] word;
   int            widx;

   assign word = addr[ADDR_W-1:2];

   always_comb begin
      widx = int'(word);
      hit  = (widx < NWORDS) && (addr[1:0] == 2'b00);
      kind = K_LEVEL;
      bank = '0;
      if (hit) begin
         kind = reg_kind_e'(3'(widx / NBANK));
         bank = BANK_W'(widx % NBANK);
      end
   end
endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice
   import gpio_bank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_kind_e         kind,
   input  logic [WORD_W-1:0] wdata,
   input  logic [WORD_W-1:0] synced,
   input  logic [WORD_W-1:0] rise_ev,
   input  logic [WORD_W-1:0] fall_ev,
   output logic [WORD_W-1:0] out_q,
   output logic [WORD_W-1:0] dir_q,
   output logic [WORD_W-1:0] stat_q,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] rise_q, fall_q;
   logic [WORD_W-1:0] out_nxt, stat_nxt, stat_clr, hits;

   always_comb begin
      out_nxt = out_q;
      if (wr_en && kind == K_SET) out_nxt = out_q | wdata;
      if (wr_en && kind == K_CLR) out_nxt = out_q & ~wdata;
      stat_clr = (wr_en && kind == K_STAT) ? wdata : '0;
      hits     = (rise_ev & rise_q) | (fall_ev & fall_q);
      stat_nxt = (stat_q & ~stat_clr) | hits;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
         stat_q <= '0;
      end else begin
         out_q  <= out_nxt;
         stat_q <= stat_nxt;
         if (wr_en && kind == K_DIR)  dir_q  <= wdata;
         if (wr_en && kind == K_RISE) rise_q <= wdata;
         if (wr_en && kind == K_FALL) fall_q <= wdata;
      end
   end

   always_comb begin
      case (kind)
         K_LEVEL: rdata = synced;
         K_DIR:   rdata = dir_q;
         K_RISE:  rdata = rise_q;
         K_FALL:  rdata = fall_q;
         K_STAT:  rdata = stat_q;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 64,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [WORD_W-1:0]   reg_wdata,
   output logic [WORD_W-1:0]   reg_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq
);
   localparam int NBANK  = NUM_PINS / WORD_W;
   localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;

   initial begin
      assert (NUM_PINS > 0 && NUM_PINS % WORD_W == 0)
         else $error("NUM_PINS must be a positive multiple of 32");
      assert (NUM_KINDS * NBANK * 4 <= 2 ** ADDR_W)
         else $error("ADDR_W too small for the register map");
      assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
   end

   logic              dec_hit;
   reg_kind_e         dec_kind;
   logic [BANK_W-1:0] dec_bank;

   logic [NUM_PINS-1:0] synced, rise_ev, fall_ev;
   logic [WORD_W-1:0]   slice_rd   [NBANK];
   logic [NBANK-1:0]    stat_any;

   gpio_addr_decode #(.NBANK(NBANK), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dec (
      .addr(reg_addr), .hit(dec_hit), .kind(dec_kind), .bank(dec_bank)
   );

   gpio_in_sync #(.W(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_in),
      .synced(synced), .rise_ev(rise_ev), .fall_ev(fall_ev)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [WORD_W-1:0] st;
      gpio_bank_slice u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_we && dec_hit && dec_bank == BANK_W'(b)),
         .kind    (dec_kind),
         .wdata   (reg_wdata),
         .synced  (synced [b*WORD_W +: WORD_W]),
         .rise_ev (rise_ev[b*WORD_W +: WORD_W]),
         .fall_ev (fall_ev[b*WORD_W +: WORD_W]),
         .out_q   (pin_out[b*WORD_W +: WORD_W]),
         .dir_q   (pin_oe [b*WORD_W +: WORD_W]),
         .stat_q  (st),
         .rdata   (slice_rd[b])
      );
      assign stat_any[b] = |st;
   end

   always_comb begin
      reg_rdata = '0;
      for (int b = 0; b < NBANK; b++)
         if (dec_hit && dec_bank == BANK_W'(b)) reg_rdata = slice_rd[b];
   end

   assign irq = |stat_any;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 64,
   parameter int BANK_W   = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_we,
   input logic                dec_hit,
   input reg_kind_e           dec_kind,
   input logic [BANK_W-1:0]   dec_bank,
   input logic [WORD_W-1:0]   reg_wdata,
   input logic [WORD_W-1:0]   reg_rdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                irq
);
   localparam int NBANK = NUM_PINS / WORD_W;

   for (genvar b = 0; b < NBANK; b++) begin : g_b
      p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we && dec_hit && dec_kind == K_SET && dec_bank == BANK_W'(b))
         |=> ((pin_out[b*WORD_W +: WORD_W] & $past(reg_wdata)) == $past(reg_wdata)));

      p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we && dec_hit && dec_kind == K_CLR && dec_bank == BANK_W'(b))
         |=> ((pin_out[b*WORD_W +: WORD_W] & $past(reg_wdata)) == '0));

      p_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we && dec_hit && dec_kind == K_DIR && dec_bank == BANK_W'(b))
         |=> (pin_oe[b*WORD_W +: WORD_W] == $past(reg_wdata)));
   end

   // R3 and R4: set and clear words read as zero
   p_rd_setclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_hit && (dec_kind == K_SET || dec_kind == K_CLR)) |-> (reg_rdata == '0));

   // R1: unmapped or misaligned addresses read as zero
   p_rd_unmapped_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_hit) |-> (reg_rdata == '0));

   // R10: status stays set without a write, so irq holds
   p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !reg_we) |=> irq);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS), .BANK_W(BANK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .dec_hit(dec_hit),
   .dec_kind(dec_kind), .dec_bank(dec_bank), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;
   localparam int NP = 64;
   localparam int NB = NP / 32;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic          irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   function automatic logic [AW-1:0] a_of(int k, int b);
      return AW'((k * NB + b) * 4);
   endfunction

   task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h exp %h", req, got, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic drive(logic [NP-1:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0]   d;
      logic [31:0]   dir_m [NB];
      logic [31:0]   rise_m [NB];
      logic [31:0]   fall_m [NB];
      logic [NP-1:0] out_m;
      logic [NP-1:0] pat;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reset state, whole address space
      chk("R2 pin_oe", pin_oe, '0);
      chk("R2 pin_out", pin_out, '0);
      chk("R2 irq", 64'(irq), 0);
      for (int w = 0; w < (1 << (AW - 2)); w++) begin
         rd(AW'(w * 4), d);
         chk("R2 reset word", 64'(d), 0);
      end

      // R1/R5/R6: address map sweep with distinct patterns
      pat = 64'hC3A5_0F96_5A3C_E187;
      drive(pat);
      for (int b = 0; b < NB; b++) begin
         dir_m[b]  = 32'h9E37_79B9 * 32'(b + 1);
         rise_m[b] = 32'h6A09_E667 ^ 32'(b * 32'h0101_0101);
         fall_m[b] = 32'hBB67_AE85 + 32'(b * 7);
         wr(a_of(1, b), dir_m[b]);
         wr(a_of(4, b), rise_m[b]);
         wr(a_of(5, b), fall_m[b]);
      end
      for (int w = 0; w < (1 << (AW - 2)); w++) begin
         logic [31:0] e;
         int k, b;
         k = w / NB; b = w % NB;
         case (k)
            0: e = pat[b*32 +: 32];
            1: e = dir_m[b];
            4: e = rise_m[b];
            5: e = fall_m[b];
            default: e = 0;
         endcase
         rd(AW'(w * 4), d);
         chk("R1 map word", 64'(d), 64'(e));
      end
      chk("R5 pin_oe", pin_oe, {dir_m[1], dir_m[0]});
      // R1: misaligned read and write are ignored
      rd(a_of(1, 1) + AW'(1), d);
      chk("R1 misaligned read", 64'(d), 0);
      wr(a_of(1, 0) + AW'(2), 32'h0);
      rd(a_of(1, 0), d);
      chk("R1 misaligned write", 64'(d), 64'(dir_m[0]));
      // R6: level write ignored
      wr(a_of(0, 0), ~pat[31:0]);
      rd(a_of(0, 0), d);
      chk("R6 level write ignored", 64'(d), 64'(pat[31:0]));
      chk("R6 no status from pattern", 64'(irq), 0);
      for (int b = 0; b < NB; b++) begin
         wr(a_of(1, b), 0); wr(a_of(4, b), 0); wr(a_of(5, b), 0);
      end
      chk("R5 inputs", pin_oe, '0);
      drive('0);
      // R6: walking level pattern
      for (int p = 0; p < NP; p += 5) begin
         drive(NP'(1) << p);
         rd(a_of(0, p / 32), d);
         chk("R6 level bit", 64'(d), 64'(32'(1) << (p % 32)));
      end
      drive('0);

      // R3: set one pin at a time
      out_m = '0;
      for (int p = 0; p < NP; p++) begin
         wr(a_of(2, p / 32), 32'(1) << (p % 32));
         out_m[p] = 1'b1;
         chk("R3 set pin", pin_out, out_m);
         if (p == 10) begin
            wr(a_of(3, 0), 0);
            chk("R4 zero clear no effect", pin_out, out_m);
         end
      end
      for (int b = 0; b < NB; b++) begin
         rd(a_of(2, b), d); chk("R3 set reads 0", 64'(d), 0);
         rd(a_of(3, b), d); chk("R4 clear reads 0", 64'(d), 0);
      end
      // R4: clear one pin at a time
      for (int p = NP - 1; p >= 0; p--) begin
         wr(a_of(3, p / 32), 32'(1) << (p % 32));
         out_m[p] = 1'b0;
         chk("R4 clear pin", pin_out, out_m);
         if (p == 40) begin
            wr(a_of(2, 1), 0);
            chk("R3 zero set no effect", pin_out, out_m);
         end
      end

      // R7: rising capture per pin, falling disabled
      for (int b = 0; b < NB; b++) wr(a_of(4, b), 32'hFFFF_FFFF);
      for (int p = 0; p < NP; p++) begin
         drive(NP'(1) << p);
         rd(a_of(6, p / 32), d);
         chk("R7 rise status", 64'(d), 64'(32'(1) << (p % 32)));
         rd(a_of(6, 1 - p / 32), d);
         chk("R7 other bank", 64'(d), 0);
         chk("R10 irq on", 64'(irq), 1);
         wr(a_of(6, p / 32), 32'(1) << (p % 32));
         rd(a_of(6, p / 32), d);
         chk("R9 w1c", 64'(d), 0);
         chk("R10 irq off", 64'(irq), 0);
         drive('0);
         rd(a_of(6, p / 32), d);
         chk("R8 fall disabled", 64'(d), 0);
      end
      // R8: falling capture per pin, rising disabled
      for (int b = 0; b < NB; b++) begin
         wr(a_of(4, b), 0); wr(a_of(5, b), 32'hFFFF_FFFF);
      end
      for (int p = 0; p < NP; p++) begin
         drive(NP'(1) << p);
         rd(a_of(6, p / 32), d);
         chk("R7 rise disabled", 64'(d), 0);
         drive('0);
         rd(a_of(6, p / 32), d);
         chk("R8 fall status", 64'(d), 64'(32'(1) << (p % 32)));
         chk("R10 irq fall", 64'(irq), 1);
         wr(a_of(6, p / 32), 32'(1) << (p % 32));
         chk("R10 irq cleared", 64'(irq), 0);
      end
      wr(a_of(5, 0), 0); wr(a_of(5, 1), 0);

      // R9: partial clear and zero writes; R10 with bank 1 only
      wr(a_of(4, 0), 32'hFFFF_FFFF); wr(a_of(4, 1), 32'hFFFF_FFFF);
      drive((NP'(1) << 3) | (NP'(1) << 40));
      wr(a_of(6, 0), 0);
      rd(a_of(6, 0), d);
      chk("R9 zero write keeps", 64'(d), 64'(32'h8));
      wr(a_of(6, 0), 32'h8);
      rd(a_of(6, 0), d);
      chk("R9 partial clear", 64'(d), 0);
      rd(a_of(6, 1), d);
      chk("R9 other bank kept", 64'(d), 64'(32'h100));
      chk("R10 irq from bank1", 64'(irq), 1);
      wr(a_of(6, 1), 32'h100);
      chk("R10 irq all clear", 64'(irq), 0);
      wr(a_of(4, 0), 0); wr(a_of(4, 1), 0);
      drive('0);

      // R9: edge detected in the same cycle as the clear wins
      wr(a_of(4, 0), 32'h20); wr(a_of(5, 0), 32'h20);
      drive(NP'(1) << 5);
      rd(a_of(6, 0), d);
      chk("R9 set before race", 64'(d), 64'(32'h20));
      @(negedge clk);
      pin_in = '0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a_of(6, 0); reg_wdata = 32'h20;
      @(negedge clk);
      reg_we = 1'b0;
      rd(a_of(6, 0), d);
      chk("R9 edge wins over clear", 64'(d), 64'(32'h20));
      wr(a_of(6, 0), 32'h20);
      rd(a_of(6, 0), d);
      chk("R9 clear after race", 64'(d), 0);
      chk("R10 irq after race", 64'(irq), 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule